// File: doc/BRIEF.md
# Composite Reset Supervisor with Window Watchdog

This block decides when a multi-domain system may leave reset and when it must go back. It watches several digital power-good group signals and a clock-lock flag. Each power-good group first passes through a filter that ignores short glitches. The filtered groups are then ANDed with the lock flag to form a combined "all good" condition. Once that condition holds without a break for a programmed number of cycles, the global reset is released. If the condition is lost, the global reset returns at the next clock edge.

A window watchdog starts running once the global reset is released. It accepts a kick only after a minimum number of cycles and no later than a maximum number of cycles after its window opened. A kick that comes too early, or no kick by the upper bound, is a watchdog event. A watchdog event pulses only the local (processor) reset and leaves the global reset released. Two sticky cause flags record power-good loss and watchdog events. A controller reads them and clears them with a write-one-to-clear strobe.

Top module: `rstsup_top`

## Requirements
- R1: While the synchronous reset `rst` is high, `glob_rst_n` and `loc_rst_n` are 0 and `cause_o` is 2'b00.
- R2: The global reset stays asserted (`glob_rst_n`=0) while any filtered power-good group or `pll_lock` is 0.
- R3: A power-good group input counts as changed only after it has held the new value for FILT_LEN consecutive clock samples. A pulse shorter than that has no effect on the outputs.
- R4: `glob_rst_n` rises only after the combined condition has been true for STRETCH_CYC consecutive clock samples. Any drop within that time restarts the count from zero.
- R5: When the combined condition is sampled false while released, `glob_rst_n` and `loc_rst_n` go to 0 at that clock edge, and `cause_o[0]` (power-good loss flag) is set. `pll_lock` is not filtered.
- R6: Counting from 0 in the first cycle of a window, a kick sampled at count WIN_MIN through WIN_MAX-1 inclusive is accepted and starts a new window. No reset results.
- R7: A kick sampled at a count below WIN_MIN is an early watchdog event.
- R8: If no kick is sampled by count WIN_MAX-1, that cycle is a late watchdog event.
- R9: A watchdog event drives `loc_rst_n` to 0 for LRST_CYC cycles, sets `cause_o[1]` (watchdog flag), and leaves `glob_rst_n` at 1.
- R10: The watchdog is idle and raises no event while either reset output is asserted. Its window opens anew when the reset is released.
- R11: A 1 on `cause_clr[i]` clears `cause_o[i]` at the next edge. If a new cause event happens in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_grp | input | N_GROUPS | Power-good group inputs, active high |
| pll_lock | input | 1 | Clock-lock indication, active high |
| wd_kick | input | 1 | Watchdog kick strobe, one cycle |
| cause_clr | input | 2 | Write-one-to-clear strobes for cause flags |
| glob_rst_n | output | 1 | Global reset, active low |
| loc_rst_n | output | 1 | Local processor reset, active low |
| cause_o | output | 2 | Cause flags: bit 0 power-good loss, bit 1 watchdog |

## Verification
The hardest case to reach is the window boundary after a local reset. The watchdog must restart its count exactly when the local pulse ends. An off-by-one there only shows up on the kick that follows the recovery. The stimulus table chains kicks with no gap between entries, so an early event is followed directly by a kick at a chosen count in the reopened window. Boundary counts WIN_MIN, WIN_MAX-1 and 0 are included. The flag clear is issued inside the local pulse, so the cleanup takes no window time. A second hard case is the set-wins rule for the cause flags. To reach it, the bench drops the lock in the same cycle as the clear strobe.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    localparam int CAUSE_W  = 2;
    localparam int CAUSE_PG = 0;
    localparam int CAUSE_WD = 1;

    // bit 1: watchdog, bit 0: power-good loss
    typedef struct packed {
        logic wd;
        logic pg;
    } cause_t;

    typedef enum logic [1:0] {
        WD_NONE,
        WD_ACCEPT,
        WD_EARLY,
        WD_LATE
    } wd_evt_e;

    // counter width able to hold the value n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rstsup_deglitch.sv
module rstsup_deglitch #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = rstsup_pkg::cnt_w(LEN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= 1'b0;
            run_q <= '0;
        end else if (din == dout) begin
            run_q <= '0;
        end else if (run_q == CW'(LEN - 1)) begin
            dout  <= din;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ok_i,
    output logic rel_o,
    output logic drop_o
);
    localparam int CW = rstsup_pkg::cnt_w(LEN);

    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || !ok_i) begin
            rel_o  <= 1'b0;
            hold_q <= '0;
        end else if (!rel_o) begin
            if (hold_q == CW'(LEN - 1)) rel_o <= 1'b1;
            else                        hold_q <= hold_q + 1'b1;
        end
    end

    // released and the condition just went away
    assign drop_o = rel_o & ~ok_i;
endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog
    import rstsup_pkg::*;
#(
    parameter int WIN_MIN = 8,
    parameter int WIN_MAX = 32
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run_i,
    input  logic    kick_i,
    output wd_evt_e evt_o
);
    localparam int TW = cnt_w(WIN_MAX);

    logic [TW-1:0] tmr_q;

    always_comb begin
        evt_o = WD_NONE;
        if (run_i) begin
            if (kick_i)
                evt_o = (tmr_q < TW'(WIN_MIN)) ? WD_EARLY : WD_ACCEPT;
            else if (tmr_q == TW'(WIN_MAX - 1))
                evt_o = WD_LATE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i)          tmr_q <= '0;
        else if (evt_o != WD_NONE)  tmr_q <= '0;
        else                        tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
    import rstsup_pkg::*;
#(
    parameter int N_GROUPS    = 3,
    parameter int FILT_LEN    = 3,
    parameter int STRETCH_CYC = 16,
    parameter int WIN_MIN     = 8,
    parameter int WIN_MAX     = 32,
    parameter int LRST_CYC    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_GROUPS-1:0] pg_grp,
    input  logic                pll_lock,
    input  logic                wd_kick,
    input  logic [CAUSE_W-1:0]  cause_clr,
    output logic                glob_rst_n,
    output logic                loc_rst_n,
    output logic [CAUSE_W-1:0]  cause_o
);
    localparam int LW = cnt_w(LRST_CYC);

    logic [N_GROUPS-1:0] pg_filt;
    logic                all_good;
    logic                released;
    logic                pg_drop;
    logic                wd_run;
    logic                wd_fire;
    logic                loc_busy;
    logic [LW-1:0]       lrst_q;
    wd_evt_e             wd_evt;
    cause_t              cause_q;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_filt
        rstsup_deglitch #(.LEN(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst  (rst),
            .din  (pg_grp[g]),
            .dout (pg_filt[g])
        );
    end

    assign all_good = (&pg_filt) & pll_lock;

    rstsup_stretch #(.LEN(STRETCH_CYC)) u_str (
        .clk    (clk),
        .rst    (rst),
        .ok_i   (all_good),
        .rel_o  (released),
        .drop_o (pg_drop)
    );

    assign loc_busy = (lrst_q != '0);
    assign wd_run   = released & ~loc_busy;

    rstsup_wdog #(.WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .run_i  (wd_run),
        .kick_i (wd_kick),
        .evt_o  (wd_evt)
    );

    assign wd_fire = (wd_evt == WD_EARLY) || (wd_evt == WD_LATE);

    always_ff @(posedge clk) begin
        if (rst)           lrst_q <= '0;
        else if (wd_fire)  lrst_q <= LW'(LRST_CYC);
        else if (loc_busy) lrst_q <= lrst_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q.pg <= pg_drop | (cause_q.pg & ~cause_clr[CAUSE_PG]);
            cause_q.wd <= wd_fire | (cause_q.wd & ~cause_clr[CAUSE_WD]);
        end
    end

    assign glob_rst_n = released;
    assign loc_rst_n  = released & ~loc_busy;
    assign cause_o    = cause_q;
endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk #(
    parameter int STRETCH_CYC = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       pll_lock,
    input logic       all_good,
    input logic       glob_rst_n,
    input logic       loc_rst_n,
    input logic [1:0] cause_o
);
    localparam int GW = rstsup_pkg::cnt_w(STRETCH_CYC);

    logic [GW-1:0] good_run;

    always_ff @(posedge clk) begin
        if (rst || !all_good)                 good_run <= '0;
        else if (good_run < GW'(STRETCH_CYC)) good_run <= good_run + 1'b1;
    end

    assert_lock_loss_R5: assert property (@(posedge clk) disable iff (rst)
        !pll_lock |=> !glob_rst_n);

    assert_glob_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(glob_rst_n) |-> $past(!all_good));

    assert_stretch_min_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(glob_rst_n) |-> (good_run >= GW'(STRETCH_CYC)));

    assert_wd_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_o[1]) |-> !loc_rst_n);

    assert_pg_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_o[0]) |-> !glob_rst_n);
endmodule

bind rstsup_top rstsup_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pll_lock   (pll_lock),
    .all_good   (all_good),
    .glob_rst_n (glob_rst_n),
    .loc_rst_n  (loc_rst_n),
    .cause_o    (cause_o)
);

// File: tb/rstsup_top_tb.sv
module rstsup_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NG   = 3;
    localparam int FILT = 3;
    localparam int STR  = 16;
    localparam int WMIN = 8;
    localparam int WMAX = 32;
    localparam int LRST = 4;
    localparam int NV   = 8;
    // kick count within the window (>= WMAX: no kick), expected event
    localparam int VJ [NV] = '{8, 31, 7, 20, 0, 99, 15, WMIN};
    localparam bit VE [NV] = '{0, 0, 1, 0, 1, 1, 0, 0};

    logic          clk = 1'b0;
    logic          rst;
    logic [NG-1:0] pg;
    logic          lock;
    logic          kick;
    logic [1:0]    clr;
    logic          glob;
    logic          loc;
    logic [1:0]    cause;
    int            total = 0;
    int            bad   = 0;
    bit            done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rstsup_top #(
        .N_GROUPS(NG), .FILT_LEN(FILT), .STRETCH_CYC(STR),
        .WIN_MIN(WMIN), .WIN_MAX(WMAX), .LRST_CYC(LRST)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pg_grp     (pg),
        .pll_lock   (lock),
        .wd_kick    (kick),
        .cause_clr  (clr),
        .glob_rst_n (glob),
        .loc_rst_n  (loc),
        .cause_o    (cause)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // local pulse recovery after a watchdog event; flag cleared inside it
    task automatic wd_recover();
        clr = 2'b10;
        step(1);
        clr = 2'b00;
        chk("R11 wd flag cleared", 32'(cause[1]), 0);
        chk("R9 loc held", 32'(loc), 0);
        chk("R9 glob kept", 32'(glob), 1);
        step(LRST - 2);
        chk("R9 loc still held", 32'(loc), 0);
        step(1);
        chk("R9 loc released", 32'(loc), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pg = '0; lock = 1'b0; kick = 1'b0; clr = 2'b00;
        step(3);
        chk("R1 glob", 32'(glob), 0);
        chk("R1 loc", 32'(loc), 0);
        chk("R1 cause", 32'(cause), 0);
        rst = 1'b0;

        // R2: one group missing, then lock missing
        pg = 3'b011; lock = 1'b1;
        step(40);
        chk("R2 group low", 32'(glob), 0);
        pg = 3'b111; lock = 1'b0;
        step(40);
        chk("R2 lock low", 32'(glob), 0);
        lock = 1'b1;
        step(STR - 1);
        chk("R4 before stretch", 32'(glob), 0);
        step(1);
        chk("R4 release", 32'(glob), 1);
        chk("R2 loc release", 32'(loc), 1);
        chk("R5 no cause at power-up", 32'(cause), 0);

        // watchdog table, window starts now
        for (int v = 0; v < NV; v++) begin
            if (VJ[v] < WMAX) begin
                step(VJ[v]);
                kick = 1'b1;
                step(1);
                kick = 1'b0;
                chk(VE[v] ? "R7 early kick" : "R6 kick accepted", 32'(loc), VE[v] ? 0 : 1);
                chk("R9 glob unaffected", 32'(glob), 1);
                if (VE[v]) begin
                    chk("R9 wd flag", 32'(cause[1]), 1);
                    wd_recover();
                end
            end else begin
                step(WMAX - 1);
                chk("R8 no event before bound", 32'(loc), 1);
                step(1);
                chk("R8 late event", 32'(loc), 0);
                chk("R8 wd flag", 32'(cause[1]), 1);
                wd_recover();
            end
        end

        // R3: short glitch ignored
        pg[1] = 1'b0;
        step(FILT - 1);
        pg[1] = 1'b1;
        step(6);
        chk("R3 glitch ignored", 32'(glob), 1);
        chk("R3 no pg flag", 32'(cause[0]), 0);

        // R3/R5: sustained drop
        pg[1] = 1'b0;
        step(FILT);
        chk("R3 filter delay", 32'(glob), 1);
        step(1);
        chk("R5 glob on drop", 32'(glob), 0);
        chk("R5 loc on drop", 32'(loc), 0);
        chk("R5 pg flag", 32'(cause[0]), 1);
        pg[1] = 1'b1;
        step(FILT + STR - 1);
        chk("R4 filter plus stretch", 32'(glob), 0);
        step(1);
        chk("R4 release after filter", 32'(glob), 1);
        clr = 2'b01;
        step(1);
        clr = 2'b00;
        chk("R11 pg flag cleared", 32'(cause[0]), 0);

        // R4: drop inside stretch restarts the count
        step(3);
        lock = 1'b0;
        step(1);
        chk("R5 lock loss immediate", 32'(glob), 0);
        lock = 1'b1;
        step(5);
        lock = 1'b0;
        step(1);
        lock = 1'b1;
        step(STR - 1);
        chk("R4 restart held", 32'(glob), 0);
        step(1);
        chk("R4 restart release", 32'(glob), 1);

        // R11: clear, then set wins over clear
        clr = 2'b01;
        step(1);
        clr = 2'b00;
        chk("R11 clear", 32'(cause[0]), 0);
        lock = 1'b0; clr = 2'b01;
        step(1);
        clr = 2'b00;
        chk("R11 set wins", 32'(cause[0]), 1);
        chk("R5 glob low", 32'(glob), 0);

        // R10: watchdog idle during global reset, window reopens on release
        clr = 2'b11;
        step(1);
        clr = 2'b00;
        step(WMAX + 10);
        chk("R10 idle no flag", 32'(cause), 0);
        chk("R10 loc held", 32'(loc), 0);
        lock = 1'b1;
        step(STR);
        chk("R10 glob released", 32'(glob), 1);
        step(WMIN);
        kick = 1'b1;
        step(1);
        kick = 1'b0;
        chk("R10 fresh window accepts", 32'(loc), 1);
        chk("R10 no wd flag", 32'(cause[1]), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule